// File: doc/BRIEF.md
# Same-Bank Refresh Timing Checker

This block sits beside the command scheduler of a memory controller for a DDR5-class device. That device has logical ranks stacked inside physical ranks, and physical ranks grouped into DIMM ranks. The block answers one question: given a candidate command and its target, what is the first cycle on which that command may legally go out? It answers for activate, plain precharge, same-bank precharge and same-bank refresh. It does this by remembering when earlier commands were issued and applying the spacing rules that involve same-bank refresh and same-bank precharge.

Each cycle, the scheduler reports the command it actually issued on the issue port. The block stamps the current cycle number into several history tables. One table is keyed by bank-in-group position, which is shared by every bank group of a logical rank. Others are keyed by logical rank, by physical rank and by DIMM rank. A rolling four-deep window per logical rank and per physical rank holds the issue times of activates and same-bank refreshes. A query placed on the query port is answered one cycle later with the earliest legal cycle. That cycle is the latest of the query cycle itself and every bound that applies. Command kinds the block does not cover raise an error flag instead.

Top module: `sbref_timing_chk`

## Requirements
- R1: A cycle counter is 1 in the first cycle after reset and then rises by one per clock. Issued commands are stamped with that count. A stamp of zero means "never issued" and sets no bound. Reset clears every stamp and window and drives all three result outputs to zero. A query sampled on one clock edge has `res_vld` high after the next edge and low otherwise. `res_time` is never earlier than the query cycle, and it equals the query cycle when no bound applies.
- R2: Command codes are ACT=0, RD=1, WR=2, PRE=3, same-bank precharge=4, all-bank refresh=5, same-bank refresh=6. The rank field is the logical rank. The physical rank is rank / LR_PER_PR, and the DIMM rank is physical / PR_PER_DR. The bank-in-group index is rank*BPG + (bank mod BPG), so banks 1 and 5 of one rank share an index but rank 0 and rank 1 do not.
- R3: An activate is held until a same-bank precharge stamp on its bank-in-group index plus TRP-1. It is also held until a same-bank refresh stamp on that index plus TRFCSB_SLR-1.
- R4: An activate is held until the last same-bank refresh on its logical rank plus TREFSBRD_SLR-1. It is also held until the last one on its physical rank plus TREFSBRD_DLR-1.
- R5: With four entries in a window, an activate is held until the oldest entry plus TFAW_SLR-1 (logical window) or TFAW_DLR-1 (physical window). With three entries there is no such bound. Each new entry pushes out the oldest.
- R6: Same-bank refreshes enter both windows like activates. A same-bank refresh query uses the full-window bound oldest+TFAW_SLR or oldest+TFAW_DLR, with no minus one.
- R7: A same-bank precharge is held until activate+TRAS+1, read+TRTP+1 and write+TWRPRE+1, all on its bank-in-group index.
- R8: Both a same-bank precharge and a plain precharge are held until TPPD after the last plain precharge and the last same-bank precharge on their physical rank.
- R9: A same-bank refresh is held until an activate on its bank-in-group index plus TRC+1, and until the last activate on its logical rank plus TRRD_L_SLR+1.
- R10: A same-bank refresh is held until TRP after a plain precharge or a same-bank precharge on its bank-in-group index.
- R11: A same-bank refresh is held after an all-bank refresh on its logical, physical and DIMM rank by TRFC_SLR, TRFC_DLR and TRFC_DPR respectively.
- R12: A same-bank refresh is held after a same-bank refresh on its logical rank by TRFCSB_SLR, and on its physical rank by TRFCSB_DLR.
- R13: A query with code 1, 2, 5 or 7 returns `res_err`=1 and `res_time`=0. Supported codes return `res_err`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_vld | input | 1 | A command was issued this cycle |
| iss_cmd | input | 3 | Code of the issued command |
| iss_rank | input | $clog2(NUM_LRANK) | Logical rank of the issued command |
| iss_bank | input | $clog2(BANKS) | Bank within the rank of the issued command |
| q_vld | input | 1 | Query valid |
| q_cmd | input | 3 | Code of the candidate command |
| q_rank | input | $clog2(NUM_LRANK) | Logical rank of the candidate |
| q_bank | input | $clog2(BANKS) | Bank of the candidate |
| res_vld | output | 1 | Result valid, one cycle after the query |
| res_err | output | 1 | Candidate command kind not covered |
| res_time | output | TW | Earliest legal issue cycle |

## Verification
A query driven before clock edge N produces its result after edge N, so the bench drives on a falling edge and compares on the falling edge that follows. An issue stamped before edge N bounds only queries sampled at edge N+1 or later. The bench therefore places its first query one cycle after the last issue and reads the stamp from its own copy of the cycle count. Each expected value is the larger of the query cycle and the bound the scenario is built to expose. A reset between scenarios keeps the bounds of one scenario from leaking into the next.

// File: rtl/sbr_pkg.sv
`timescale 1ns/1ps
package sbr_pkg;
  localparam int CMD_W = 3;

  typedef enum logic [CMD_W-1:0] {
    CMD_ACT    = 3'd0,
    CMD_RD     = 3'd1,
    CMD_WR     = 3'd2,
    CMD_PRE    = 3'd3,
    CMD_PRE_SB = 3'd4,
    CMD_REF_AB = 3'd5,
    CMD_REF_SB = 3'd6,
    CMD_RSVD   = 3'd7
  } cmd_e;

  // Kinds the block can compute an earliest cycle for
  function automatic logic is_query_cmd(input logic [CMD_W-1:0] c);
    return (c == CMD_ACT) || (c == CMD_PRE) || (c == CMD_PRE_SB) || (c == CMD_REF_SB);
  endfunction

  // Kinds that occupy a slot of the four-deep activate window
  function automatic logic is_window_cmd(input logic [CMD_W-1:0] c);
    return (c == CMD_ACT) || (c == CMD_REF_SB);
  endfunction
endpackage

// File: rtl/sbr_stamp_table.sv
`timescale 1ns/1ps
// One issue-time stamp per index; single write port, one asynchronous read.
module sbr_stamp_table #(
  parameter int N  = 4,
  parameter int TW = 32,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  logic [TW-1:0] wtime,
  input  logic [IW-1:0] ridx,
  output logic [TW-1:0] rtime
);
  logic [TW-1:0] mem [N];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) mem[i] <= '0;
    end else if (we) begin
      mem[widx] <= wtime;
    end
  end

  assign rtime = mem[ridx];
endmodule

// File: rtl/sbr_act_window.sv
`timescale 1ns/1ps
// Rolling window of the last DEPTH activate-class issue times.
module sbr_act_window #(
  parameter int DEPTH = 4,
  parameter int TW    = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [TW-1:0] ptime,
  output logic          full,
  output logic [TW-1:0] oldest
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [TW-1:0] slot [DEPTH];
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      for (int i = 0; i < DEPTH; i++) slot[i] <= '0;
    end else if (push) begin
      slot[0] <= ptime;
      for (int i = 1; i < DEPTH; i++) slot[i] <= slot[i-1];
      if (cnt != CW'(DEPTH)) cnt <= cnt + 1'b1;
    end
  end

  assign full   = (cnt == CW'(DEPTH));
  assign oldest = slot[DEPTH-1];
endmodule

// File: rtl/sbref_timing_chk.sv
`timescale 1ns/1ps
module sbref_timing_chk
  import sbr_pkg::*;
#(
  parameter int NUM_LRANK   = 8,
  parameter int LR_PER_PR   = 2,
  parameter int PR_PER_DR   = 2,
  parameter int BANKS       = 8,
  parameter int BPG         = 4,
  parameter int WIN_DEPTH   = 4,
  parameter int TW          = 32,
  parameter int TRP         = 15,
  parameter int TRAS        = 39,
  parameter int TRTP        = 12,
  parameter int TWRPRE      = 40,
  parameter int TPPD        = 5,
  parameter int TRC         = 54,
  parameter int TRRD_L_SLR  = 8,
  parameter int TRFC_SLR    = 312,
  parameter int TRFC_DLR    = 104,
  parameter int TRFC_DPR    = 52,
  parameter int TRFCSB_SLR  = 184,
  parameter int TRFCSB_DLR  = 62,
  parameter int TREFSBRD_SLR = 48,
  parameter int TREFSBRD_DLR = 24,
  parameter int TFAW_SLR    = 90,
  parameter int TFAW_DLR    = 70,
  localparam int LRW = (NUM_LRANK > 1) ? $clog2(NUM_LRANK) : 1,
  localparam int BKW = (BANKS > 1) ? $clog2(BANKS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             iss_vld,
  input  logic [CMD_W-1:0] iss_cmd,
  input  logic [LRW-1:0]   iss_rank,
  input  logic [BKW-1:0]   iss_bank,
  input  logic             q_vld,
  input  logic [CMD_W-1:0] q_cmd,
  input  logic [LRW-1:0]   q_rank,
  input  logic [BKW-1:0]   q_bank,
  output logic             res_vld,
  output logic             res_err,
  output logic [TW-1:0]    res_time
);
  localparam int BIGN      = NUM_LRANK * BPG;
  localparam int BIGW      = (BIGN > 1) ? $clog2(BIGN) : 1;
  localparam int NUM_PRANK = NUM_LRANK / LR_PER_PR;
  localparam int PRW       = (NUM_PRANK > 1) ? $clog2(NUM_PRANK) : 1;
  localparam int NUM_DRANK = NUM_PRANK / PR_PER_DR;
  localparam int DRW       = (NUM_DRANK > 1) ? $clog2(NUM_DRANK) : 1;

  // Gaps, in cycles, from a past stamp to the earliest legal cycle
  localparam int G_ACT_PRESB   = TRP - 1;
  localparam int G_ACT_REFSB   = TRFCSB_SLR - 1;
  localparam int G_ACT_RDL     = TREFSBRD_SLR - 1;
  localparam int G_ACT_RDD     = TREFSBRD_DLR - 1;
  localparam int G_ACT_FAWL    = TFAW_SLR - 1;
  localparam int G_ACT_FAWD    = TFAW_DLR - 1;
  localparam int G_PSB_ACT     = TRAS + 1;
  localparam int G_PSB_RD      = TRTP + 1;
  localparam int G_PSB_WR      = TWRPRE + 1;
  localparam int G_RSB_ACT     = TRC + 1;
  localparam int G_RSB_ACTL    = TRRD_L_SLR + 1;

  // ---------------- index mapping ----------------
  function automatic logic [BIGW-1:0] big_of(input logic [LRW-1:0] r, input logic [BKW-1:0] b);
    return BIGW'(32'(r) * BPG + 32'(b) % BPG);
  endfunction
  function automatic logic [PRW-1:0] pr_of(input logic [LRW-1:0] r);
    return PRW'(32'(r) / LR_PER_PR);
  endfunction
  function automatic logic [DRW-1:0] dr_of(input logic [LRW-1:0] r);
    return DRW'(32'(r) / (LR_PER_PR * PR_PER_DR));
  endfunction

  // Raise cur to stamp+gap when the stamp is a real issue time
  function automatic logic [TW-1:0] lift(input logic [TW-1:0] cur, input logic [TW-1:0] stamp,
                                         input int gap);
    logic [TW-1:0] cand;
    cand = stamp + TW'(gap);
    return ((stamp != '0) && (cand > cur)) ? cand : cur;
  endfunction

  // ---------------- time base ----------------
  logic [TW-1:0] now;
  always_ff @(posedge clk) begin
    if (rst) now <= TW'(1);
    else     now <= now + 1'b1;
  end

  logic [BIGW-1:0] iss_big, q_big;
  logic [PRW-1:0]  iss_pr, q_pr;
  logic [DRW-1:0]  iss_dr, q_dr;
  assign iss_big = big_of(iss_rank, iss_bank);
  assign q_big   = big_of(q_rank, q_bank);
  assign iss_pr  = pr_of(iss_rank);
  assign q_pr    = pr_of(q_rank);
  assign iss_dr  = dr_of(iss_rank);
  assign q_dr    = dr_of(q_rank);

  logic w_act, w_rd, w_wr, w_pre, w_psb, w_rab, w_rsb;
  assign w_act = iss_vld && (iss_cmd == CMD_ACT);
  assign w_rd  = iss_vld && (iss_cmd == CMD_RD);
  assign w_wr  = iss_vld && (iss_cmd == CMD_WR);
  assign w_pre = iss_vld && (iss_cmd == CMD_PRE);
  assign w_psb = iss_vld && (iss_cmd == CMD_PRE_SB);
  assign w_rab = iss_vld && (iss_cmd == CMD_REF_AB);
  assign w_rsb = iss_vld && (iss_cmd == CMD_REF_SB);

  // ---------------- stamp tables ----------------
  logic [TW-1:0] bg_act, bg_rd, bg_wr, bg_pre, bg_psb, bg_rsb;
  logic [TW-1:0] lr_act, lr_rsb, lr_rab;
  logic [TW-1:0] pr_pre, pr_psb, pr_rsb, pr_rab;
  logic [TW-1:0] dr_rab;

  sbr_stamp_table #(.N(BIGN), .TW(TW)) u_bg_act (.clk(clk), .rst(rst), .we(w_act), .widx(iss_big), .wtime(now), .ridx(q_big), .rtime(bg_act));
  sbr_stamp_table #(.N(BIGN), .TW(TW)) u_bg_rd  (.clk(clk), .rst(rst), .we(w_rd),  .widx(iss_big), .wtime(now), .ridx(q_big), .rtime(bg_rd));
  sbr_stamp_table #(.N(BIGN), .TW(TW)) u_bg_wr  (.clk(clk), .rst(rst), .we(w_wr),  .widx(iss_big), .wtime(now), .ridx(q_big), .rtime(bg_wr));
  sbr_stamp_table #(.N(BIGN), .TW(TW)) u_bg_pre (.clk(clk), .rst(rst), .we(w_pre), .widx(iss_big), .wtime(now), .ridx(q_big), .rtime(bg_pre));
  sbr_stamp_table #(.N(BIGN), .TW(TW)) u_bg_psb (.clk(clk), .rst(rst), .we(w_psb), .widx(iss_big), .wtime(now), .ridx(q_big), .rtime(bg_psb));
  sbr_stamp_table #(.N(BIGN), .TW(TW)) u_bg_rsb (.clk(clk), .rst(rst), .we(w_rsb), .widx(iss_big), .wtime(now), .ridx(q_big), .rtime(bg_rsb));

  sbr_stamp_table #(.N(NUM_LRANK), .TW(TW)) u_lr_act (.clk(clk), .rst(rst), .we(w_act), .widx(iss_rank), .wtime(now), .ridx(q_rank), .rtime(lr_act));
  sbr_stamp_table #(.N(NUM_LRANK), .TW(TW)) u_lr_rsb (.clk(clk), .rst(rst), .we(w_rsb), .widx(iss_rank), .wtime(now), .ridx(q_rank), .rtime(lr_rsb));
  sbr_stamp_table #(.N(NUM_LRANK), .TW(TW)) u_lr_rab (.clk(clk), .rst(rst), .we(w_rab), .widx(iss_rank), .wtime(now), .ridx(q_rank), .rtime(lr_rab));

  sbr_stamp_table #(.N(NUM_PRANK), .TW(TW)) u_pr_pre (.clk(clk), .rst(rst), .we(w_pre), .widx(iss_pr), .wtime(now), .ridx(q_pr), .rtime(pr_pre));
  sbr_stamp_table #(.N(NUM_PRANK), .TW(TW)) u_pr_psb (.clk(clk), .rst(rst), .we(w_psb), .widx(iss_pr), .wtime(now), .ridx(q_pr), .rtime(pr_psb));
  sbr_stamp_table #(.N(NUM_PRANK), .TW(TW)) u_pr_rsb (.clk(clk), .rst(rst), .we(w_rsb), .widx(iss_pr), .wtime(now), .ridx(q_pr), .rtime(pr_rsb));
  sbr_stamp_table #(.N(NUM_PRANK), .TW(TW)) u_pr_rab (.clk(clk), .rst(rst), .we(w_rab), .widx(iss_pr), .wtime(now), .ridx(q_pr), .rtime(pr_rab));

  sbr_stamp_table #(.N(NUM_DRANK), .TW(TW)) u_dr_rab (.clk(clk), .rst(rst), .we(w_rab), .widx(iss_dr), .wtime(now), .ridx(q_dr), .rtime(dr_rab));

  // ---------------- activate windows ----------------
  logic          win_push;
  logic          lw_full [NUM_LRANK];
  logic [TW-1:0] lw_old  [NUM_LRANK];
  logic          pw_full [NUM_PRANK];
  logic [TW-1:0] pw_old  [NUM_PRANK];

  assign win_push = iss_vld && is_window_cmd(iss_cmd);

  for (genvar g = 0; g < NUM_LRANK; g++) begin : g_lwin
    sbr_act_window #(.DEPTH(WIN_DEPTH), .TW(TW)) u_win (
      .clk(clk), .rst(rst), .push(win_push && (iss_rank == LRW'(g))),
      .ptime(now), .full(lw_full[g]), .oldest(lw_old[g]));
  end
  for (genvar g = 0; g < NUM_PRANK; g++) begin : g_pwin
    sbr_act_window #(.DEPTH(WIN_DEPTH), .TW(TW)) u_win (
      .clk(clk), .rst(rst), .push(win_push && (iss_pr == PRW'(g))),
      .ptime(now), .full(pw_full[g]), .oldest(pw_old[g]));
  end

  // ---------------- bound evaluation ----------------
  logic          q_ok;
  logic [TW-1:0] bound;
  assign q_ok = is_query_cmd(q_cmd);

  always_comb begin
    bound = now;
    case (q_cmd)
      CMD_ACT: begin
        bound = lift(bound, bg_psb, G_ACT_PRESB);
        bound = lift(bound, bg_rsb, G_ACT_REFSB);
        bound = lift(bound, lr_rsb, G_ACT_RDL);
        bound = lift(bound, pr_rsb, G_ACT_RDD);
        if (lw_full[q_rank]) bound = lift(bound, lw_old[q_rank], G_ACT_FAWL);
        if (pw_full[q_pr])   bound = lift(bound, pw_old[q_pr], G_ACT_FAWD);
      end
      CMD_PRE: begin
        bound = lift(bound, pr_pre, TPPD);
        bound = lift(bound, pr_psb, TPPD);
      end
      CMD_PRE_SB: begin
        bound = lift(bound, bg_act, G_PSB_ACT);
        bound = lift(bound, bg_rd,  G_PSB_RD);
        bound = lift(bound, bg_wr,  G_PSB_WR);
        bound = lift(bound, pr_pre, TPPD);
        bound = lift(bound, pr_psb, TPPD);
      end
      CMD_REF_SB: begin
        bound = lift(bound, bg_act, G_RSB_ACT);
        bound = lift(bound, lr_act, G_RSB_ACTL);
        bound = lift(bound, bg_pre, TRP);
        bound = lift(bound, bg_psb, TRP);
        bound = lift(bound, lr_rab, TRFC_SLR);
        bound = lift(bound, pr_rab, TRFC_DLR);
        bound = lift(bound, dr_rab, TRFC_DPR);
        bound = lift(bound, lr_rsb, TRFCSB_SLR);
        bound = lift(bound, pr_rsb, TRFCSB_DLR);
        if (lw_full[q_rank]) bound = lift(bound, lw_old[q_rank], TFAW_SLR);
        if (pw_full[q_pr])   bound = lift(bound, pw_old[q_pr], TFAW_DLR);
      end
      default: bound = now;
    endcase
  end

  // ---------------- registered result ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      res_vld  <= 1'b0;
      res_err  <= 1'b0;
      res_time <= '0;
    end else begin
      res_vld <= q_vld;
      if (q_vld) begin
        res_err  <= !q_ok;
        res_time <= q_ok ? bound : '0;
      end
    end
  end
endmodule

// File: rtl/sbref_timing_chk_sva.sv
`timescale 1ns/1ps
module sbref_timing_chk_sva
  import sbr_pkg::*;
#(
  parameter int TW = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             q_vld,
  input logic [CMD_W-1:0] q_cmd,
  input logic             res_vld,
  input logic             res_err,
  input logic [TW-1:0]    res_time,
  input logic [TW-1:0]    now
);
  assert_result_follows_query_R1: assert property (@(posedge clk) disable iff (rst)
    q_vld |=> res_vld);

  assert_no_spurious_result_R1: assert property (@(posedge clk) disable iff (rst)
    !q_vld |=> !res_vld);

  assert_time_advances_R1: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (now == $past(now) + 1'b1));

  assert_not_before_query_R1: assert property (@(posedge clk) disable iff (rst)
    (res_vld && !res_err) |-> (res_time >= $past(now)));

  assert_unsupported_flags_R13: assert property (@(posedge clk) disable iff (rst)
    (q_vld && !is_query_cmd(q_cmd)) |=> (res_err && (res_time == '0)));

  assert_supported_clear_R13: assert property (@(posedge clk) disable iff (rst)
    (q_vld && is_query_cmd(q_cmd)) |=> !res_err);
endmodule

bind sbref_timing_chk sbref_timing_chk_sva #(.TW(TW)) u_sva (
  .clk(clk), .rst(rst), .q_vld(q_vld), .q_cmd(q_cmd),
  .res_vld(res_vld), .res_err(res_err), .res_time(res_time), .now(now));

// File: tb/sbref_timing_chk_bench.sv
`timescale 1ns/1ps
module sbref_timing_chk_bench;
  import sbr_pkg::*;

  localparam int NLR = 8, LPP = 2, PPD = 2, NBK = 8, BPGV = 4, TWV = 32;
  localparam int P_TRP = 15, P_TRAS = 39, P_TRTP = 12, P_TWRPRE = 40, P_TPPD = 5;
  localparam int P_TRC = 54, P_TRRDL = 8, P_RFC_S = 312, P_RFC_D = 104, P_RFC_P = 52;
  localparam int P_RFCSB_S = 184, P_RFCSB_D = 62, P_SBRD_S = 48, P_SBRD_D = 24;
  localparam int P_FAW_S = 90, P_FAW_D = 70;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic iss_vld = 1'b0, q_vld = 1'b0;
  logic [2:0] iss_cmd = '0, q_cmd = '0;
  logic [2:0] iss_rank = '0, iss_bank = '0, q_rank = '0, q_bank = '0;
  logic res_vld, res_err;
  logic [TWV-1:0] res_time;

  always #2.5 clk = ~clk;

  sbref_timing_chk #(
    .NUM_LRANK(NLR), .LR_PER_PR(LPP), .PR_PER_DR(PPD), .BANKS(NBK), .BPG(BPGV), .TW(TWV),
    .TRP(P_TRP), .TRAS(P_TRAS), .TRTP(P_TRTP), .TWRPRE(P_TWRPRE), .TPPD(P_TPPD),
    .TRC(P_TRC), .TRRD_L_SLR(P_TRRDL), .TRFC_SLR(P_RFC_S), .TRFC_DLR(P_RFC_D),
    .TRFC_DPR(P_RFC_P), .TRFCSB_SLR(P_RFCSB_S), .TRFCSB_DLR(P_RFCSB_D),
    .TREFSBRD_SLR(P_SBRD_S), .TREFSBRD_DLR(P_SBRD_D), .TFAW_SLR(P_FAW_S), .TFAW_DLR(P_FAW_D)
  ) u_sbref_timing_chk (
    .clk(clk), .rst(rst), .iss_vld(iss_vld), .iss_cmd(iss_cmd), .iss_rank(iss_rank),
    .iss_bank(iss_bank), .q_vld(q_vld), .q_cmd(q_cmd), .q_rank(q_rank), .q_bank(q_bank),
    .res_vld(res_vld), .res_err(res_err), .res_time(res_time));

  typedef struct { logic err; logic [31:0] t; string tag; } exp_t;
  exp_t exp_q[$];
  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] tb_now = 32'd1;

  // Cycle count as R1 defines it
  always @(posedge clk) tb_now <= rst ? 32'd1 : tb_now + 32'd1;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard as results appear
  always @(negedge clk) begin
    if (!rst && res_vld) begin
      exp_t e;
      if (exp_q.size() == 0) chk(1'b0, "R1 result with no query", 32'(res_vld), 0);
      else begin
        e = exp_q.pop_front();
        chk(res_err == e.err, {e.tag, " err flag"}, 32'(res_err), 32'(e.err));
        chk(res_time == e.t, e.tag, res_time, e.t);
      end
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic issue(input logic [2:0] c, input int r, input int b, output logic [31:0] st);
    iss_vld = 1'b1; iss_cmd = c; iss_rank = 3'(r); iss_bank = 3'(b);
    st = tb_now;
    @(negedge clk);
    iss_vld = 1'b0;
  endtask

  // bnd = 0 means no bound is expected
  task automatic ask(input logic [2:0] c, input int r, input int b, input logic [31:0] bnd,
                     input string tag);
    exp_t e;
    e.err = 1'b0; e.t = (bnd > tb_now) ? bnd : tb_now; e.tag = tag;
    exp_q.push_back(e);
    q_vld = 1'b1; q_cmd = c; q_rank = 3'(r); q_bank = 3'(b);
    @(negedge clk);
    q_vld = 1'b0;
  endtask

  task automatic ask_bad(input logic [2:0] c, input string tag);
    exp_t e;
    e.err = 1'b1; e.t = '0; e.tag = tag;
    exp_q.push_back(e);
    q_vld = 1'b1; q_cmd = c; q_rank = '0; q_bank = '0;
    @(negedge clk);
    q_vld = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R1 watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] a, b, c, d, e4;
    do_reset();
    // R1: reset state and unconstrained query
    chk(res_vld == 1'b0 && res_err == 1'b0 && res_time == '0, "R1 reset outputs",
        32'(res_vld) + 32'(res_err) + res_time, 0);
    ask(CMD_ACT, 0, 0, 0, "R1 empty history");
    @(negedge clk);
    chk(res_vld == 1'b0, "R1 valid drops", 32'(res_vld), 0);

    // R1: reset clears history
    issue(CMD_PRE_SB, 0, 1, a);
    do_reset();
    ask(CMD_ACT, 0, 5, 0, "R1 history cleared");

    // R2 / R3: activate after same-bank precharge, shared index
    do_reset();
    issue(CMD_PRE_SB, 0, 1, a);
    ask(CMD_ACT, 0, 5, a + P_TRP - 1, "R3 R2 act after presb same index");
    ask(CMD_ACT, 0, 2, 0, "R2 other index");
    ask(CMD_ACT, 1, 1, 0, "R2 other rank");

    // R3 / R4: activate after same-bank refresh
    do_reset();
    issue(CMD_REF_SB, 0, 0, a);
    ask(CMD_ACT, 0, 4, a + P_RFCSB_S - 1, "R3 act after refsb same index");
    ask(CMD_ACT, 0, 1, a + P_SBRD_S - 1, "R4 act after refsb logical rank");
    ask(CMD_ACT, 1, 1, a + P_SBRD_D - 1, "R4 act after refsb physical rank");
    ask(CMD_ACT, 2, 0, 0, "R4 other physical rank");

    // R5: four-activate window
    do_reset();
    issue(CMD_ACT, 0, 0, a);
    issue(CMD_ACT, 0, 1, b);
    issue(CMD_ACT, 0, 2, c);
    ask(CMD_ACT, 0, 0, 0, "R5 three entries no bound");
    issue(CMD_ACT, 0, 3, d);
    ask(CMD_ACT, 0, 0, a + P_FAW_S - 1, "R5 logical window full");
    ask(CMD_ACT, 1, 0, a + P_FAW_D - 1, "R5 physical window full");
    ask(CMD_ACT, 2, 0, 0, "R5 other physical rank");
    issue(CMD_ACT, 0, 0, e4);
    ask(CMD_ACT, 0, 1, b + P_FAW_S - 1, "R5 window slides");

    // R6: same-bank refresh fills the window, refresh query without minus one
    do_reset();
    issue(CMD_REF_SB, 2, 0, a);
    issue(CMD_ACT, 3, 0, b);
    issue(CMD_ACT, 3, 1, c);
    issue(CMD_ACT, 3, 2, d);
    ask(CMD_ACT, 3, 3, a + P_FAW_D - 1, "R6 refsb counted in window");
    ask(CMD_REF_SB, 3, 3, a + P_FAW_D, "R6 refsb window bound");

    // R7: same-bank precharge after act/read/write
    do_reset();
    issue(CMD_ACT, 0, 2, a);
    issue(CMD_RD, 0, 2, b);
    issue(CMD_WR, 0, 6, c);
    ask(CMD_PRE_SB, 0, 2, c + P_TWRPRE + 1, "R7 write dominates");
    ask(CMD_PRE_SB, 1, 2, 0, "R7 other index");
    do_reset();
    issue(CMD_RD, 0, 3, a);
    ask(CMD_PRE_SB, 0, 7, a + P_TRTP + 1, "R7 after read");
    do_reset();
    issue(CMD_ACT, 5, 0, a);
    ask(CMD_PRE_SB, 5, 4, a + P_TRAS + 1, "R7 after activate");

    // R8: precharge spacing on physical rank
    do_reset();
    issue(CMD_PRE, 0, 0, a);
    ask(CMD_PRE_SB, 1, 1, a + P_TPPD, "R8 presb after pre");
    ask(CMD_PRE, 1, 3, a + P_TPPD, "R8 pre after pre");
    ask(CMD_PRE, 2, 0, 0, "R8 other physical rank");
    do_reset();
    issue(CMD_PRE_SB, 0, 0, a);
    ask(CMD_PRE, 1, 2, a + P_TPPD, "R8 pre after presb");
    repeat (10) @(negedge clk);
    ask(CMD_PRE, 1, 2, 0, "R8 expired");

    // R9: same-bank refresh after activate
    do_reset();
    issue(CMD_ACT, 0, 1, a);
    ask(CMD_REF_SB, 0, 5, a + P_TRC + 1, "R9 refsb after act same index");
    ask(CMD_REF_SB, 0, 2, a + P_TRRDL + 1, "R9 refsb after act logical rank");
    ask(CMD_REF_SB, 1, 1, 0, "R9 other logical rank");

    // R10: same-bank refresh after precharges
    do_reset();
    issue(CMD_PRE, 0, 1, a);
    ask(CMD_REF_SB, 0, 5, a + P_TRP, "R10 refsb after pre");
    do_reset();
    issue(CMD_PRE_SB, 1, 2, a);
    ask(CMD_REF_SB, 1, 6, a + P_TRP, "R10 refsb after presb");
    ask(CMD_REF_SB, 1, 3, 0, "R10 other index");

    // R11: after all-bank refresh
    do_reset();
    issue(CMD_REF_AB, 0, 0, a);
    ask(CMD_REF_SB, 0, 0, a + P_RFC_S, "R11 logical rank");
    ask(CMD_REF_SB, 1, 0, a + P_RFC_D, "R11 physical rank");
    ask(CMD_REF_SB, 2, 0, a + P_RFC_P, "R11 dimm rank");
    ask(CMD_REF_SB, 4, 0, 0, "R11 other dimm rank");

    // R12: after same-bank refresh
    do_reset();
    issue(CMD_REF_SB, 0, 0, a);
    ask(CMD_REF_SB, 0, 1, a + P_RFCSB_S, "R12 logical rank");
    ask(CMD_REF_SB, 1, 1, a + P_RFCSB_D, "R12 physical rank");
    ask(CMD_REF_SB, 2, 1, 0, "R12 other physical rank");

    // R13: unsupported kinds
    do_reset();
    ask_bad(CMD_RD, "R13 read query");
    ask_bad(CMD_WR, "R13 write query");
    ask_bad(CMD_REF_AB, "R13 all-bank refresh query");
    ask_bad(CMD_RSVD, "R13 reserved code");
    ask(CMD_PRE_SB, 0, 0, 0, "R13 supported clears flag");

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R1 all results delivered", 32'(exp_q.size()), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule